// File: doc/BRIEF.md
# Serializing Manchester Line Encoder

The block takes a parallel data word, shifts it out one bit at a time, most significant bit first, and turns each bit into two half-bit symbols on a single output line. Its clock runs at twice the bit rate, so every data bit takes two clock cycles. The first cycle carries the first half-bit and the second cycle carries the second half-bit. A clock-enable input qualifies every edge, and a synchronous reset returns the block to idle.

A word is accepted when a load strobe is seen while the block is idle and enabled. The busy flag then stays high for the whole conversion. When the last half-bit has been sent, busy drops and a one-cycle done pulse is raised. Outside a conversion the line sits low. The line is also forced low, without waiting for a clock edge, whenever reset is asserted or the enable is low. While the enable is low, the conversion holds its place and resumes where it left off.

Top module: `manch_ser_enc`

## Requirements
- R1: After a synchronous reset, line, busy and done are all 0.
- R2: A load seen at a clock edge with en high and busy low captures data. Busy is 1 from the next cycle and stays high for exactly 2*WORD_W enabled cycles.
- R3: A data bit of 1 is sent as line 0 in its first half-bit cycle and line 1 in its second half-bit cycle, so the line rises at mid-bit.
- R4: A data bit of 0 is sent as line 1 in its first half-bit cycle and line 0 in its second half-bit cycle, so the line falls at mid-bit.
- R5: Bits are sent from data[WORD_W-1] down to data[0].
- R6: In the cycle after the last half-bit, busy is 0 and done is 1. Done is high for exactly one cycle.
- R7: A load that arrives while busy is 1 is ignored. The word being sent and the length of the conversion are unchanged.
- R8: While en is 0, line is 0 and the conversion is frozen. Busy keeps its value, and the waveform continues from the same half-bit once en returns to 1.
- R9: While busy is 0, line is 0.
- R10: While rst is 1, line is 0 at once. A reset during a conversion aborts it, leaving busy and done at 0.
- R11: A load in the cycle where done is 1 starts the next word without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high; also forces line low |
| en | input | 1 | Clock enable; when low, freezes state and forces line low |
| load | input | 1 | Request to start converting data |
| data | input | WORD_W | Parallel word to send, MSB first |
| line | output | 1 | Manchester-coded serial output |
| busy | output | 1 | High while a word is being converted |
| done | output | 1 | One-cycle pulse after the last half-bit |

## Verification
On every cycle, the assertions check the following: the line is low when idle, disabled or in reset; done is a single-cycle pulse that coincides with busy being low; every conversion spans exactly 2*WORD_W enabled cycles; and the state is clear after reset. The bench scenarios cover the rest. They check the actual half-bit levels and mid-bit transitions for each bit value, the MSB-first order, and that an ignored load leaves the word intact. They also check that a disabled stretch resumes at the same half-bit, that a reset aborts a conversion, and that a back-to-back load is accepted on the done cycle.

// File: rtl/manch_enc_pkg.sv
package manch_enc_pkg;

    // Which half of the bit period is on the line
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    // Level of the internal bit-rate clock during a half-bit:
    // high in the first half, low in the second
    function automatic logic bit_clk_level(input half_e h);
        return (h == HALF_FIRST);
    endfunction

endpackage

// File: rtl/manch_seq.sv
module manch_seq
    import manch_enc_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  load,
    output logic  capture,
    output logic  advance,
    output logic  busy,
    output logic  done,
    output half_e half
);

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        half_e            half;
        logic [IDX_W-1:0] idx;
    } seq_t;

    localparam seq_t SEQ_RST = '{busy: 1'b0, done: 1'b0, half: HALF_FIRST, idx: '0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        capture    = 1'b0;
        advance    = 1'b0;
        if (en) begin
            if (!seq_q.busy) begin
                if (load) begin
                    capture    = 1'b1;
                    seq_d.busy = 1'b1;
                    seq_d.half = HALF_FIRST;
                    seq_d.idx  = IDX_TOP;
                end
            end else if (seq_q.half == HALF_FIRST) begin
                seq_d.half = HALF_SECOND;
            end else begin
                advance    = 1'b1;
                seq_d.half = HALF_FIRST;
                if (seq_q.idx == '0) begin
                    seq_d.busy = 1'b0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
    assign done = seq_q.done;
    assign half = seq_q.half;

endmodule

// File: rtl/manch_shreg.sv
module manch_shreg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              advance,
    input  logic [WORD_W-1:0] word,
    output logic              cur_bit
);

    logic [WORD_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (capture)      sr_d = word;
        else if (advance) sr_d = sr_q << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign cur_bit = sr_q[WORD_W-1];

endmodule

// File: rtl/manch_coder.sv
module manch_coder
    import manch_enc_pkg::*;
(
    input  logic  rst,
    input  logic  en,
    input  logic  busy,
    input  logic  cur_bit,
    input  half_e half,
    output logic  line
);

    logic gate_ok;

    always_comb begin
        gate_ok = en & ~rst & busy;
        line    = gate_ok & (cur_bit ^ bit_clk_level(half));
    end

endmodule

// File: rtl/manch_ser_enc.sv
module manch_ser_enc
    import manch_enc_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [WORD_W-1:0] data,
    output logic              line,
    output logic              busy,
    output logic              done
);

    logic  capture;
    logic  advance;
    logic  cur_bit;
    half_e half;

    manch_seq #(.WORD_W(WORD_W)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .load    (load),
        .capture (capture),
        .advance (advance),
        .busy    (busy),
        .done    (done),
        .half    (half)
    );

    manch_shreg #(.WORD_W(WORD_W)) shreg_i (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .advance (advance),
        .word    (data),
        .cur_bit (cur_bit)
    );

    manch_coder coder_i (
        .rst     (rst),
        .en      (en),
        .busy    (busy),
        .cur_bit (cur_bit),
        .half    (half),
        .line    (line)
    );

endmodule

// File: rtl/manch_ser_enc_chk.sv
module manch_ser_enc_chk #(
    parameter int WORD_W = 8
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic load,
    input logic line,
    input logic busy,
    input logic done
);

    localparam int LEN   = 2 * WORD_W;
    localparam int CNT_W = $clog2(LEN + 2) + 1;

    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst || done) len_q <= '0;
        else if (busy && en) len_q <= len_q + 1'b1;
    end

    // R1: state clear in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    // R2: conversion spans exactly 2*WORD_W enabled cycles
    p_length_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (len_q == CNT_W'(LEN)));

    // R6: done is a single-cycle pulse with busy low
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: a busy conversion only ends through done
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && load) |=> (busy || done));

    // R8: disabled line is low and busy is held
    p_disabled_low_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !line);
    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(busy));

    // R9: idle line is low
    p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line);

endmodule

bind manch_ser_enc manch_ser_enc_chk #(.WORD_W(WORD_W)) chk_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .load (load),
    .line (line),
    .busy (busy),
    .done (done)
);

// File: tb/manch_ser_enc_tb_top.sv
`timescale 1ns/1ps
module manch_ser_enc_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] data = '0;
    logic         line, busy, done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    manch_ser_enc #(.WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .load(load), .data(data),
        .line(line), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // R2: load at current negedge, return sampling the first half-bit
    task automatic start_word(input logic [W-1:0] w);
        load = 1'b1;
        data = w;
        @(negedge clk);
        load = 1'b0;
        data = '0;
        #1;
        chk("R2 busy after load", busy, 1);
    endtask

    // R3/R4/R5: check half-bits from..to of word w, MSB first
    task automatic run_halves(input logic [W-1:0] w, input int from, input int to);
        for (int h = from; h <= to; h++) begin
            logic b;
            b = w[W-1-h/2];
            if (b) chk((h % 2 == 0) ? "R3 one first half" : "R3 one second half", line, (h % 2 == 0) ? 0 : 1);
            else   chk((h % 2 == 0) ? "R4 zero first half" : "R4 zero second half", line, (h % 2 == 0) ? 1 : 0);
            chk("R2 busy during word", busy, 1);
            step();
        end
    endtask

    task automatic end_check();
        chk("R6 busy low at end", busy, 0);
        chk("R6 done pulse", done, 1);
        chk("R9 idle line", line, 0);
        step();
        chk("R6 done one cycle", done, 0);
        chk("R9 idle line after", line, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) step();
        chk("R1 line", line, 0);
        chk("R10 line in reset", line, 0);
        rst = 1'b0;
        step();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic t_word(input logic [W-1:0] w);
        start_word(w);
        run_halves(w, 0, 2*W-1);
        end_check();
    endtask

    task automatic t_load_busy();
        start_word(8'h3C);
        run_halves(8'h3C, 0, 2);
        load = 1'b1;
        data = 8'hFF;
        run_halves(8'h3C, 3, 3);
        load = 1'b0;
        data = '0;
        run_halves(8'h3C, 4, 2*W-1);
        chk("R7 no restart", done, 1);
        end_check();
    endtask

    task automatic t_enable_gap();
        start_word(8'h96);
        run_halves(8'h96, 0, 5);
        en = 1'b0;
        #1;
        for (int i = 0; i < 3; i++) begin
            chk("R8 line low disabled", line, 0);
            chk("R8 busy held", busy, 1);
            step();
        end
        en = 1'b1;
        #1;
        run_halves(8'h96, 6, 2*W-1);
        end_check();
    endtask

    task automatic t_reset_mid();
        start_word(8'hF0);
        run_halves(8'hF0, 0, 4);
        rst = 1'b1;
        #1;
        chk("R10 line low at reset", line, 0);
        step();
        chk("R10 busy aborted", busy, 0);
        chk("R10 done clear", done, 0);
        rst = 1'b0;
        step();
        chk("R10 still idle", busy, 0);
    endtask

    task automatic t_back2back();
        start_word(8'hC3);
        run_halves(8'hC3, 0, 2*W-1);
        chk("R11 done before reload", done, 1);
        start_word(8'h5A);
        chk("R11 no gap", done, 0);
        run_halves(8'h5A, 0, 2*W-1);
        end_check();
    endtask

    initial begin
        step();
        t_reset();
        t_word(8'hA5);
        t_word(8'h00);
        t_word(8'hFF);
        t_word(8'h80);
        t_load_busy();
        t_enable_gap();
        t_reset_mid();
        t_back2back();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule